// File: doc/BRIEF.md
# SHA-1 Paired Message Schedule

This block expands one 512-bit message block into the eighty 32-bit schedule words that a SHA-1 compression datapath uses. It returns them as forty word pairs, one pair per clock, and each word already carries the round constant of its group. The round logic therefore needs only one further addition per word.

A block is presented as sixteen 32-bit words on a single wide bus. A one-cycle `load` pulse accepts it. The block keeps a sixteen-word sliding window as eight 64-bit pairs.
- The first eight steps replay the stored pairs.
- Each later step builds two new words from the window and writes them over the oldest pair.

The operand three words back does not fall on a pair boundary, so it is taken from two neighbouring pairs. An optional byte-reversal path accepts blocks gathered in little-endian order. When the forty pairs have been sent, `done` rises and stays high until the next block is accepted.

Top module: `wps_top`

## Requirements
- R1: After reset `ready` is 1 and `pair_vld` and `done` are 0. A `load` sampled high while `ready` is 1 accepts the block on `blk`.
- R2: With `swap_bytes` at 0, schedule word j (0..15) is `blk[511-32*j -: 32]`, taken as written: word 0 sits in the top 32 bits.
- R3: With `swap_bytes` at 1, the four bytes of each of the sixteen words are reversed at acceptance, before the words are stored.
- R4: Pair p is output with `pair_idx`=p, `wk_even` = W[2p]+K and `wk_odd` = W[2p+1]+K. The sum is modulo 2^32. For p = 0..7 the words are the stored block words.
- R5: For t = 16..79, W[t] is W[t-3] xor W[t-8] xor W[t-14] xor W[t-16], rotated left by one bit.
- R6: K is 0x5A827999 for words 0..19, 0x6ED9EBA1 for 20..39, 0x8F1BBCDC for 40..59 and 0xCA62C1D6 for 60..79.
- R7: From the cycle after acceptance, `pair_vld` is high for exactly 40 consecutive cycles, with `pair_idx` running 0 to 39 in order.
- R8: A `load` while `ready` is 0 is ignored: the pairs being output are unchanged.
- R9: `done` goes high the cycle after pair 39 is shown, with `pair_vld` low. It stays high until the next block is accepted. `ready` is 1 while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Accept request for the block on `blk` |
| swap_bytes | input | 1 | Reverse the byte order inside each word at acceptance |
| blk | input | 512 | Message block; word 0 in bits 511:480 |
| ready | output | 1 | Block can accept a `load` |
| pair_vld | output | 1 | A pair is present on the outputs |
| pair_idx | output | 6 | Index of the pair shown (0..39) |
| wk_even | output | 32 | W[2p] plus its round constant |
| wk_odd | output | 32 | W[2p+1] plus its round constant |
| done | output | 1 | All forty pairs of the current block have been output |

## Verification
The assertions assume that reset is applied before the first edge. They make no assumption about the timing of `load`: it may be high in any cycle, and a request during a run must leave the counter and the window advancing undisturbed. They also assume that `blk` and `swap_bytes` matter only in the accepting cycle. The stimulus therefore changes `blk` freely outside that cycle, and it raises `load` in the middle of a run with a different block to confirm that the request is ignored.

// File: rtl/wps_pkg.sv
package wps_pkg;
  localparam int WORD_W      = 32;
  localparam int PAIR_W      = 2 * WORD_W;
  localparam int WIN_WORDS   = 16;
  localparam int WIN_PAIRS   = WIN_WORDS / 2;
  localparam int TOTAL_PAIRS = 40;
  localparam int GRP_PAIRS   = 10;
  localparam int NUM_GRPS    = TOTAL_PAIRS / GRP_PAIRS;
  localparam int IDX_W       = $clog2(TOTAL_PAIRS);
  localparam int GRP_W       = $clog2(NUM_GRPS);
  localparam int BLK_W       = WIN_WORDS * WORD_W;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [PAIR_W-1:0] pair_t;

  function automatic word_t rotl1(input word_t x);
    return {x[WORD_W-2:0], x[WORD_W-1]};
  endfunction

  function automatic word_t bswap(input word_t x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  function automatic word_t k_of(input logic [GRP_W-1:0] g);
    case (g)
      2'd0:    return 32'h5A827999;
      2'd1:    return 32'h6ED9EBA1;
      2'd2:    return 32'h8F1BBCDC;
      default: return 32'hCA62C1D6;
    endcase
  endfunction

  // Pairs are packed {earlier word, later word}. o16 is the oldest pair and
  // n2 the newest. The t-3 operand of the even word is the later half of
  // pair n4, which lies across a pair boundary.
  function automatic pair_t expand(input pair_t o16, input pair_t o14,
                                   input pair_t o8, input pair_t n4,
                                   input pair_t n2);
    word_t ev, od;
    ev = rotl1(n4[WORD_W-1:0] ^ o8[PAIR_W-1:WORD_W] ^
               o14[PAIR_W-1:WORD_W] ^ o16[PAIR_W-1:WORD_W]);
    od = rotl1(n2[PAIR_W-1:WORD_W] ^ o8[WORD_W-1:0] ^
               o14[WORD_W-1:0] ^ o16[WORD_W-1:0]);
    return {ev, od};
  endfunction
endpackage

// File: rtl/wps_ctrl.sv
module wps_ctrl
  import wps_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  output logic             ready,
  output logic             accept,
  output logic             step,
  output logic             use_stored,
  output logic [IDX_W-1:0] cnt
);
  typedef enum logic {S_IDLE, S_RUN} st_t;
  st_t st;
  logic last;

  assign ready      = (st == S_IDLE);
  assign accept     = load && ready;
  assign step       = (st == S_RUN);
  assign last       = (cnt == IDX_W'(TOTAL_PAIRS - 1));
  assign use_stored = (cnt < IDX_W'(WIN_PAIRS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else if (accept) begin
      st  <= S_RUN;
      cnt <= '0;
    end else if (step) begin
      cnt <= last ? '0 : cnt + 1'b1;
      if (last) st <= S_IDLE;
    end
  end

  // R7: counter never passes the last pair while running
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> cnt <= IDX_W'(TOTAL_PAIRS - 1));
  // R8: a load during a run neither restarts nor stalls the count
  a_r8_load_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (step && load && !last) |=> step && cnt == $past(cnt) + 1'b1);
  // R1: acceptance always starts at pair zero
  a_r1_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> step && cnt == '0);
endmodule

// File: rtl/wps_window.sv
module wps_window
  import wps_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             swap_bytes,
  input  logic [BLK_W-1:0] blk,
  input  logic             step,
  input  logic             use_stored,
  output pair_t            sel_pair
);
  pair_t slot [WIN_PAIRS];
  pair_t load_pair [WIN_PAIRS];
  pair_t fresh;

  for (genvar i = 0; i < WIN_PAIRS; i++) begin : g_load
    word_t raw_e, raw_o;
    assign raw_e = blk[BLK_W-1-(2*i)*WORD_W -: WORD_W];
    assign raw_o = blk[BLK_W-1-(2*i+1)*WORD_W -: WORD_W];
    assign load_pair[i] = swap_bytes ? {bswap(raw_e), bswap(raw_o)}
                                     : {raw_e, raw_o};
  end

  assign fresh    = expand(slot[0], slot[1], slot[4], slot[6], slot[7]);
  assign sel_pair = use_stored ? slot[0] : fresh;

  for (genvar i = 0; i < WIN_PAIRS; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      slot[i] <= '0;
      else if (accept) slot[i] <= load_pair[i];
      else if (step) begin
        if (i == WIN_PAIRS - 1) slot[i] <= sel_pair;
        else                    slot[i] <= slot[i+1];
      end
    end
  end

  // R5: window advances one pair per step, oldest pair leaves first
  a_r5_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !accept) |=> slot[0] == $past(slot[1]));
  // R5: the pair produced enters as the newest entry
  a_r5_newest: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !accept) |=> slot[WIN_PAIRS-1] == $past(sel_pair));
  // R2: acceptance captures the formatted block words
  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> slot[0] == $past(load_pair[0]));
endmodule

// File: rtl/wps_kgen.sv
module wps_kgen
  import wps_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             step,
  input  logic [IDX_W-1:0] cnt,
  output logic [GRP_W-1:0] grp,
  output word_t            kval
);
  logic boundary;

  assign boundary = (cnt == IDX_W'(GRP_PAIRS * (int'(grp) + 1) - 1)) &&
                    (grp != GRP_W'(NUM_GRPS - 1));
  assign kval = k_of(grp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                grp <= '0;
    else if (accept)           grp <= '0;
    else if (step && boundary) grp <= grp + 1'b1;
  end

  // R6: the next constant is staged right after a group's final pair
  a_r6_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (step && boundary && !accept) |=> grp == $past(grp) + 1'b1);
  // R6: outside a boundary the constant is held
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !(step && boundary)) |=> $stable(grp));
endmodule

// File: rtl/wps_top.sv
module wps_top
  import wps_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               swap_bytes,
  input  logic [511:0]       blk,
  output logic               ready,
  output logic               pair_vld,
  output logic [5:0]         pair_idx,
  output logic [31:0]        wk_even,
  output logic [31:0]        wk_odd,
  output logic               done
);
  logic             accept, step, use_stored;
  logic [IDX_W-1:0] cnt;
  logic [GRP_W-1:0] grp;
  word_t            kval;
  pair_t            sel_pair;
  logic             last_shown;

  wps_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .load(load), .ready(ready),
    .accept(accept), .step(step), .use_stored(use_stored), .cnt(cnt)
  );

  wps_window u_win (
    .clk(clk), .rst_n(rst_n), .accept(accept), .swap_bytes(swap_bytes),
    .blk(blk), .step(step), .use_stored(use_stored), .sel_pair(sel_pair)
  );

  wps_kgen u_kgen (
    .clk(clk), .rst_n(rst_n), .accept(accept), .step(step), .cnt(cnt),
    .grp(grp), .kval(kval)
  );

  assign last_shown = pair_vld && (pair_idx == IDX_W'(TOTAL_PAIRS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_vld <= 1'b0;
      pair_idx <= '0;
      wk_even  <= '0;
      wk_odd   <= '0;
    end else begin
      pair_vld <= step;
      if (step) begin
        pair_idx <= cnt;
        wk_even  <= sel_pair[PAIR_W-1:WORD_W] + kval;
        wk_odd   <= sel_pair[WORD_W-1:0] + kval;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          done <= 1'b0;
    else if (accept)     done <= 1'b0;
    else if (last_shown) done <= 1'b1;
  end

  // R9: done never overlaps a valid pair
  a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !pair_vld && ready);
  // R7: valid pairs follow each other with rising index
  a_r7_sequence: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_vld && !last_shown) |=> pair_vld && pair_idx == $past(pair_idx) + 1'b1);
  // R6: constant group tracks the pair index
  a_r6_group_match: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> int'(grp) == int'(cnt) / GRP_PAIRS);
endmodule

// File: tb/wps_top_tb.sv
module wps_top_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load = 1'b0;
  logic         swap_bytes = 1'b0;
  logic [511:0] blk = '0;
  logic         ready, pair_vld, done;
  logic [5:0]   pair_idx;
  logic [31:0]  wk_even, wk_odd;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  logic [31:0] ref_w [80];

  always #4 clk = ~clk;

  wps_top u_dut (
    .clk(clk), .rst_n(rst_n), .load(load), .swap_bytes(swap_bytes),
    .blk(blk), .ready(ready), .pair_vld(pair_vld), .pair_idx(pair_idx),
    .wk_even(wk_even), .wk_odd(wk_odd), .done(done)
  );

  function automatic logic [31:0] rev4(input logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  function automatic logic [31:0] kfor(input int t);
    if (t < 20)      return 32'h5A827999;
    else if (t < 40) return 32'h6ED9EBA1;
    else if (t < 60) return 32'h8F1BBCDC;
    else             return 32'hCA62C1D6;
  endfunction

  // reference schedule, words taken from blk in big-endian order
  task automatic build_ref(input logic [511:0] b, input bit sw);
    for (int j = 0; j < 16; j++) begin
      logic [31:0] v;
      v = b[511 - 32*j -: 32];
      ref_w[j] = sw ? rev4(v) : v;
    end
    for (int t = 16; t < 80; t++) begin
      logic [31:0] x;
      x = ref_w[t-3] ^ ref_w[t-8] ^ ref_w[t-14] ^ ref_w[t-16];
      ref_w[t] = (x << 1) | (x >> 31);
    end
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // R4 R5 R6 R7 R8 R9: run one block and compare all forty pairs
  task automatic run_block(input logic [511:0] b, input bit sw,
                           input bit intrude, input string tag);
    build_ref(b, sw);
    @(negedge clk);
    check(ready, "R1", {tag, " ready before load"}, 64'(ready), 64'd1);
    blk = b; swap_bytes = sw; load = 1'b1;
    @(negedge clk);
    load = 1'b0; blk = ~b; swap_bytes = ~sw;
    check(!pair_vld && !ready, "R7", {tag, " busy after accept"},
          64'({pair_vld, ready}), 64'd0);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (intrude) load = (i == 5);
      check(pair_vld && pair_idx == 6'(i) &&
            wk_even == ref_w[2*i] + kfor(2*i) &&
            wk_odd == ref_w[2*i+1] + kfor(2*i+1),
            intrude ? "R8" : (i < 8 ? "R4" : (i % 10 == 0 ? "R6" : "R5")),
            $sformatf("%s pair %0d", tag, i),
            {wk_even, wk_odd},
            {ref_w[2*i] + kfor(2*i), ref_w[2*i+1] + kfor(2*i+1)});
    end
    load = 1'b0;
    @(negedge clk);
    check(done && !pair_vld && ready, "R9", {tag, " done after last"},
          64'({done, pair_vld, ready}), 64'b101);
  endtask

  initial begin
    logic [511:0] abc, abc_le, rb;
    abc = '0;
    abc[511:480] = 32'h61626380;
    abc[31:0]    = 32'h00000018;
    abc_le = '0;
    for (int j = 0; j < 16; j++) abc_le[511-32*j -: 32] = rev4(abc[511-32*j -: 32]);

    repeat (3) @(negedge clk);
    // R1: reset state
    check(ready && !pair_vld && !done, "R1", "reset state",
          64'({ready, pair_vld, done}), 64'b100);
    rst_n = 1'b1;

    // R2 R4: known first pair of a standard padded block
    @(negedge clk);
    blk = abc; load = 1'b1;
    @(negedge clk); load = 1'b0;
    @(negedge clk);
    check(wk_even == 32'hBBE4DD19 && wk_odd == 32'h5A827999, "R2",
          "big-endian word 0 plus K", {wk_even, wk_odd},
          {32'hBBE4DD19, 32'h5A827999});
    repeat (45) @(negedge clk);

    run_block(abc, 1'b0, 1'b0, "abc");
    // R3: byte-reversed input gives the same schedule
    run_block(abc_le, 1'b1, 1'b0, "swapped");
    run_block('0, 1'b0, 1'b0, "zero");
    run_block({16{32'hFFFFFFFF}}, 1'b0, 1'b0, "ones");
    for (int n = 0; n < 3; n++) begin
      for (int j = 0; j < 16; j++) rb[32*j +: 32] = $urandom;
      run_block(rb, n[0], 1'b0, "random");
    end
    // R8: load during a run is ignored
    for (int j = 0; j < 16; j++) rb[32*j +: 32] = $urandom;
    run_block(rb, 1'b0, 1'b1, "intrude");
    // R9: done holds until the next acceptance
    repeat (4) @(negedge clk);
    check(done && ready, "R9", "done held", 64'({done, ready}), 64'b11);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R7 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule